// File: doc/BRIEF.md
# Three-Wire Panel Register Serial Master

This block performs single register writes and reads on a display panel's configuration port over a three-wire serial link. The link has an active-low select line, a serial clock, and one data line that both ends share. Outbound data leaves on `sio_dout` and is qualified by `sio_oe`. Inbound data arrives on `sio_din`. The pad's tristate buffer sits outside the block.

A host starts a transfer with a one-cycle `start` pulse. With the pulse it gives the direction, an 8-bit register index and, for a write, a data byte. The block then runs the sequence below and returns to idle:

1. Setup phase.
2. Sixteen serial bit slots.
3. Turnaround of the data line, for reads only.
4. A mandatory quiet gap.

At the end it pulses `done`; for a read, `rd_data` holds the byte it received. The run-time input `half_div` sets the length of each serial clock half-period in system clock cycles. A mode input selects how the register index is turned into the address byte that goes on the wire. Another input selects whether the serial clock rests high or low between frames.

Top module: `panel_sio_master`

## Requirements
- R1: A write frame carries 16 bits, most significant first. The upper byte is the encoded address and the lower byte is `wr_data`.
- R2: `sio_cs_n` is high whenever the block is idle. It falls once per frame and rises after the sixteenth serial clock rising edge.
- R3: Within a frame, each bit slot has `sio_clk` low for one half-period and then high for one half-period. `sio_dout` changes only while `sio_clk` is low. A half-period lasts `half_div`+1 system clock cycles, and a frame has exactly 16 rising edges.
- R4: A read sends the encoded address with bit 7 set to 1. `sio_oe` goes low after the eighth rising edge and stays low for the last 8 rising edges. `sio_din` is sampled at each of those 8 rising edges, most significant bit first, and the result appears on `rd_data` when `done` pulses.
- R5: `done` rises exactly 8·(`half_div`+1) system clock cycles after `sio_cs_n` rises (GAP_HALVES = 8 half-periods). No new frame can start within that gap.
- R6: `addr_mode` encodes index `a` as follows: 1 sends `{a[5:0],2'b00}`; 2 sends `{a[5:0],2'b10}`; 0 and 3 send `a` unchanged. The read marker of R4 is applied after this encoding.
- R7: Whenever the block is busy with `sio_cs_n` high, `sio_clk` sits at the level of `clk_idle_hi`. With the input high, the clock is pulled low at the start of the first bit.
- R8: After a start is accepted, `sio_dout` is held low with `sio_cs_n` high for exactly one half-period. `sio_cs_n` then falls.
- R9: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`. `done` lasts one cycle. A `start` pulse that arrives while busy has no effect.
- R10: `sio_oe` is high again once `sio_cs_n` rises at the end of a read, and it stays high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle transfer request |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 8 | Register index before encoding |
| wr_data | input | 8 | Data byte for writes |
| half_div | input | DIV_W (8) | Serial clock half-period minus one, in system clock cycles |
| addr_mode | input | 2 | Address encoding select (R6) |
| clk_idle_hi | input | 1 | Serial clock rest level |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte received by the last read |
| sio_cs_n | output | 1 | Active-low frame select |
| sio_clk | output | 1 | Serial clock |
| sio_dout | output | 1 | Outbound data bit |
| sio_oe | output | 1 | Output enable for the shared data pad |
| sio_din | input | 1 | Inbound data bit from the pad |

## Verification
The in-RTL assertions cover the properties that hold on every cycle:
- `sio_cs_n` stays high while idle, and the output enable is low only inside a read frame.
- The data bit stays steady across each high clock phase.
- Before every falling select edge, the data line is low and the block is in the setup phase.
- `busy` rises only in response to `start`, and `done` lasts a single cycle.

The directed scenarios show what needs a whole frame to judge:
- The bit order and address encodings.
- The exact setup, half-period and gap lengths for several divider settings.
- The turnaround point, and the bits collected from a bench-driven panel response.
- That a second start during a frame leaves no trace.

// File: rtl/sio_pkg.sv
// Shared types and sizes for the three-wire panel serial master.
// Assumes a fixed 16-bit frame made of an address byte and a data byte.
package sio_pkg;
    localparam int BYTE_BITS  = 8;
    localparam int FRAME_BITS = 2 * BYTE_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LO    = 3'd2,
        ST_HI    = 3'd3,
        ST_GAP   = 3'd4
    } sio_state_t;
endpackage

// File: rtl/sio_half_tick.sv
// Half-period strobe generator. Produces a one-cycle tick every half_div+1
// cycles while run is high; the count restarts from zero whenever run is low.
// Assumes half_div is held steady during a transfer.
module sio_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_div);

    // Count system cycles within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sio_addr_enc.sv
// Maps a register index to the address byte sent on the wire, per framing
// mode, and sets the read marker bit afterwards. Purely combinational.
module sio_addr_enc (
    input  logic [1:0] mode,
    input  logic       is_read,
    input  logic [7:0] index,
    output logic [7:0] code
);
    logic [7:0] framed;

    // Pick the framing variant.
    always_comb begin
        case (mode)
            2'd1:    framed = {index[5:0], 2'b00};
            2'd2:    framed = {index[5:0], 2'b10};
            default: framed = index;
        endcase
    end

    assign code = is_read ? (framed | 8'h80) : framed;
endmodule

// File: rtl/sio_frame_ctrl.sv
// Frame sequencer: setup delay, 16 bit slots (low half then high half),
// data-line turnaround for reads, then a quiet gap before completion.
// Assumes the tick input comes from a half-period generator that runs while busy.
module sio_frame_ctrl
    import sio_pkg::*;
#(
    parameter int GAP_HALVES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rd_nwr,
    input  logic [BYTE_BITS-1:0] addr_code,
    input  logic [BYTE_BITS-1:0] wr_data,
    input  logic                 clk_idle_hi,
    input  logic                 tick,
    input  logic                 sio_din,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 sio_cs_n,
    output logic                 sio_clk,
    output logic                 sio_dout,
    output logic                 sio_oe
);
    localparam int GAP_W = $clog2(GAP_HALVES + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TURN_BIT = CNT_W'(BYTE_BITS - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_HALVES - 1);

    sio_state_t              state;
    logic [FRAME_BITS-1:0]   shreg;
    logic [CNT_W-1:0]        bit_cnt;
    logic [GAP_W-1:0]        gap_cnt;
    logic                    is_rd;
    logic [BYTE_BITS-1:0]    rx;

    assign busy = (state != ST_IDLE);

    // Sequence the frame and drive the link pins from registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            gap_cnt  <= '0;
            is_rd    <= 1'b0;
            rx       <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
            sio_cs_n <= 1'b1;
            sio_clk  <= 1'b0;
            sio_dout <= 1'b0;
            sio_oe   <= 1'b1;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    sio_clk  <= clk_idle_hi;
                    sio_cs_n <= 1'b1;
                    sio_dout <= 1'b0;
                    sio_oe   <= 1'b1;
                    if (start) begin
                        shreg <= rd_nwr ? {addr_code, {BYTE_BITS{1'b0}}}
                                        : {addr_code, wr_data};
                        is_rd <= rd_nwr;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        sio_cs_n <= 1'b0;
                        sio_clk  <= 1'b0;
                        sio_dout <= shreg[FRAME_BITS-1];
                        bit_cnt  <= '0;
                        state    <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (tick) begin
                        sio_clk <= 1'b1;
                        state   <= ST_HI;
                        if (is_rd && (bit_cnt > TURN_BIT))
                            rx <= {rx[BYTE_BITS-2:0], sio_din};
                    end
                end
                ST_HI: begin
                    if (tick) begin
                        if (bit_cnt == LAST_BIT) begin
                            sio_cs_n <= 1'b1;
                            sio_clk  <= clk_idle_hi;
                            sio_dout <= 1'b0;
                            sio_oe   <= 1'b1;
                            gap_cnt  <= '0;
                            if (is_rd)
                                rd_data <= rx;
                            state    <= ST_GAP;
                        end else begin
                            bit_cnt  <= bit_cnt + 1'b1;
                            shreg    <= {shreg[FRAME_BITS-2:0], 1'b0};
                            sio_dout <= shreg[FRAME_BITS-2];
                            sio_clk  <= 1'b0;
                            state    <= ST_LO;
                            if (is_rd && (bit_cnt == TURN_BIT))
                                sio_oe <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_cnt == GAP_LAST) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Select stays high whenever no transfer is running.
    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> sio_cs_n);

    // Data bit holds steady across each high clock phase inside a frame.
    assert_dout_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sio_cs_n && sio_clk && $past(sio_clk) && !$past(sio_cs_n)) |-> $stable(sio_dout));

    // Output enable is released only inside a read frame.
    assert_oe_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sio_oe |-> (!sio_cs_n && is_rd));

    // Select falls only after a setup phase with the data line low.
    assert_setup_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sio_cs_n) |-> ($past(sio_dout) == 1'b0 && $past(state) == ST_SETUP));

    // Busy is entered only from a start request.
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // Completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/panel_sio_master.sv
// Top of the three-wire panel register serial master. Joins the address
// encoder, half-period tick generator and frame sequencer.
// Assumes half_div, addr_mode and clk_idle_hi are steady during a transfer.
module panel_sio_master
    import sio_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int GAP_HALVES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rd_nwr,
    input  logic [BYTE_BITS-1:0] reg_addr,
    input  logic [BYTE_BITS-1:0] wr_data,
    input  logic [DIV_W-1:0]     half_div,
    input  logic [1:0]           addr_mode,
    input  logic                 clk_idle_hi,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 sio_cs_n,
    output logic                 sio_clk,
    output logic                 sio_dout,
    output logic                 sio_oe,
    input  logic                 sio_din
);
    logic [BYTE_BITS-1:0] addr_code;
    logic                 tick;

    sio_addr_enc u_enc (
        .mode    (addr_mode),
        .is_read (rd_nwr),
        .index   (reg_addr),
        .code    (addr_code)
    );

    sio_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_div (half_div),
        .tick     (tick)
    );

    sio_frame_ctrl #(.GAP_HALVES(GAP_HALVES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rd_nwr      (rd_nwr),
        .addr_code   (addr_code),
        .wr_data     (wr_data),
        .clk_idle_hi (clk_idle_hi),
        .tick        (tick),
        .sio_din     (sio_din),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .sio_cs_n    (sio_cs_n),
        .sio_clk     (sio_clk),
        .sio_dout    (sio_dout),
        .sio_oe      (sio_oe)
    );
endmodule

// File: tb/panel_sio_master_tb.sv
`timescale 1ns/1ps
module panel_sio_master_tb;
    localparam int GAP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] half_div = 8'd0;
    logic [1:0] addr_mode = 2'd0;
    logic       clk_idle_hi = 1'b0;
    logic       busy, done, sio_cs_n, sio_clk, sio_dout, sio_oe, sio_din;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    panel_sio_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .reg_addr(reg_addr), .wr_data(wr_data), .half_div(half_div),
        .addr_mode(addr_mode), .clk_idle_hi(clk_idle_hi), .busy(busy),
        .done(done), .rd_data(rd_data), .sio_cs_n(sio_cs_n), .sio_clk(sio_clk),
        .sio_dout(sio_dout), .sio_oe(sio_oe), .sio_din(sio_din)
    );

    // Bench monitor and panel model state
    int cyc = 0;
    int nbits, t_busy, t_csfall, t_rise0, t_csrise, t_done;
    int done_cnt, csfall_cnt, viol_dout, viol_idle;
    logic [15:0] cap, oecap;
    logic [7:0]  resp = 8'h00;
    logic pcs = 1'b1, psclk = 1'b0, pdout = 1'b0, pbusy = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    assign sio_din = (nbits >= 8 && nbits < 16) ? resp[15 - nbits] : 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !pbusy) t_busy = cyc;
            if (pcs && !sio_cs_n) begin t_csfall = cyc; csfall_cnt++; end
            if (!pcs && sio_cs_n) t_csrise = cyc;
            if (!sio_cs_n && !psclk && sio_clk) begin
                if (nbits == 0) t_rise0 = cyc;
                cap   = {cap[14:0], sio_dout};
                oecap = {oecap[14:0], sio_oe};
                nbits++;
            end
            if (!sio_cs_n && !pcs && psclk && sio_clk && sio_dout != pdout) viol_dout++;
            if (busy && sio_cs_n && sio_clk != clk_idle_hi) viol_idle++;
            if (done) begin t_done = cyc; done_cnt++; end
        end
        pcs = sio_cs_n; psclk = sio_clk; pdout = sio_dout; pbusy = busy;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [1:0] m, input logic [7:0] a, input bit rd);
        logic [7:0] v;
        case (m)
            2'd1:    v = {a[5:0], 2'b00};
            2'd2:    v = {a[5:0], 2'b10};
            default: v = a;
        endcase
        return rd ? (v | 8'h80) : v;
    endfunction

    task automatic clear_mon();
        nbits = 0; cap = '0; oecap = '0; done_cnt = 0; csfall_cnt = 0;
        viol_dout = 0; viol_idle = 0;
        t_busy = 0; t_csfall = 0; t_rise0 = 0; t_csrise = 0; t_done = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // One full transfer with every frame-level check.
    task automatic run_frame(input bit rd, input logic [7:0] a, input logic [7:0] d,
                             input logic [1:0] m, input bit ihi, input int hd,
                             input logic [7:0] rsp);
        int hp;
        logic [7:0] exp_a;
        hp = hd + 1;
        exp_a = enc(m, a, rd);
        @(negedge clk);
        rd_nwr = rd; reg_addr = a; wr_data = d; addr_mode = m;
        clk_idle_hi = ihi; half_div = 8'(hd); resp = rsp;
        repeat (3) @(negedge clk);
        clear_mon();
        pulse_start();
        wait_done();
        chk(done_cnt == 1, "R9 done count", done_cnt, 1);
        chk(nbits == 16, "R3 rising edges", nbits, 16);
        chk(cap[15:8] == exp_a, "R6 address byte", cap[15:8], exp_a);
        if (!rd) chk(cap[7:0] == d, "R1 data byte", cap[7:0], d);
        chk(t_csfall - t_busy == hp, "R8 setup length", t_csfall - t_busy, hp);
        chk(t_rise0 - t_csfall == hp, "R3 half-period", t_rise0 - t_csfall, hp);
        chk(t_done - t_csrise == GAP * hp, "R5 gap length", t_done - t_csrise, GAP * hp);
        chk(viol_dout == 0, "R3 data steady while clock high", viol_dout, 0);
        chk(viol_idle == 0, "R7 clock rest level", viol_idle, 0);
        if (rd) begin
            chk(oecap == 16'hFF00, "R4 turnaround", oecap, 16'hFF00);
            chk(rd_data == rsp, "R4 read data", rd_data, rsp);
        end else begin
            chk(oecap == 16'hFFFF, "R1 oe during write", oecap, 16'hFFFF);
        end
        repeat (2) @(negedge clk);
        chk(sio_oe && sio_cs_n && !busy, "R10 idle after frame",
            {sio_oe, sio_cs_n, busy}, 3'b110);
        chk(sio_clk == ihi, "R7 idle clock", sio_clk, ihi);
    endtask

    task automatic test_reset();
        chk(sio_cs_n == 1'b1, "R2 reset select", sio_cs_n, 1);
        chk(!busy && !done, "R9 reset busy/done", {busy, done}, 0);
        chk(sio_oe && !sio_dout, "R10 reset oe/dout", {sio_oe, sio_dout}, 2'b10);
    endtask

    // A second start inside a frame must leave no trace.
    task automatic test_busy_ignore();
        @(negedge clk);
        rd_nwr = 1'b0; reg_addr = 8'h21; wr_data = 8'h9C; addr_mode = 2'd0;
        clk_idle_hi = 1'b0; half_div = 8'd1;
        repeat (3) @(negedge clk);
        clear_mon();
        pulse_start();
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R9 busy during frame", busy, 1);
        reg_addr = 8'h44; wr_data = 8'h11;
        pulse_start();
        reg_addr = 8'h21; wr_data = 8'h9C;
        wait_done();
        repeat (60) @(negedge clk);
        chk(cap == 16'h219C, "R9 frame unchanged", cap, 16'h219C);
        chk(csfall_cnt == 1, "R9 ignored start", csfall_cnt, 1);
        chk(done_cnt == 1, "R9 single done", done_cnt, 1);
        chk(!busy, "R2 idle after ignored start", busy, 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_frame(1'b0, 8'h3A, 8'hC5, 2'd0, 1'b0, 2, 8'h00);   // R1 plain write
        run_frame(1'b0, 8'h05, 8'h10, 2'd1, 1'b1, 0, 8'h00);   // R6 shift-by-two, R7 idle high
        run_frame(1'b0, 8'h03, 8'hC9, 2'd2, 1'b0, 1, 8'h00);   // R6 shift with bit 1 set
        run_frame(1'b1, 8'h12, 8'h00, 2'd0, 1'b0, 3, 8'hA6);   // R4 read
        run_frame(1'b1, 8'h0B, 8'h00, 2'd2, 1'b1, 0, 8'h5B);   // R4 read with framing
        run_frame(1'b0, 8'hE7, 8'h3C, 2'd3, 1'b0, 0, 8'h00);   // R6 mode 3 as is
        test_busy_ignore();
        finish_run();
    end
endmodule